// File: doc/BRIEF.md
# Comma-Aligned Receive Word Output with Logic-Generated Strobes

This block sits at the parallel side of a receive path. It accepts one 10-bit code-group per word period, delays it through a fixed pipeline and presents it on a registered output bus. Next to the bus it drives one or two strobes, made from registers in the same clock domain, that downstream logic uses as capture clocks. The internal clock runs at twice the word rate. An input tick marks the cycle in which a new code-group arrives, and the ticks come every other cycle.

A mode input selects the strobe scheme. With the mode low, a single strobe gives one rising edge in the middle of every word. With the mode high, two complementary strobes run at half the word rate, so each word gets one rising edge, on the two strobes in turn. In this mode the block looks one word ahead in its pipeline. When a comma is about to follow a non-comma word that would land it on the wrong strobe, the block holds both strobes for one word period. The preceding word is then shown without an edge, and the comma arrives on a rising edge of strobe B. A runs of commas is passed through with no adjustment and no clock disturbance. A comma flag, gated by an enable input, marks comma words on the bus.

Top module: `rxcg_aligner`

## Requirements
- R1: A code-group is a comma when its bits [6:0] equal 7'b1111100 or 7'b0000011. Bit 0 is the first bit on the line, so these are the line patterns 0011111 and 1100000.
- R2: `comma_det` is high exactly when `det_en` is high and the word on `out_cg` is a comma. It follows `det_en` in the same cycle.
- R3: With `rate_half` low, `out_stb_b` is low in the cycle after each tick edge and rises at the next edge, giving one rising edge per word. `out_stb_a` is held high.
- R4: With `rate_half` high, `out_stb_a` is always the complement of `out_stb_b`. Each word not being held gets exactly one rising edge, alternating between B and A.
- R5: With `rate_half` high, every comma whose preceding output word is not a comma is presented on a rising edge of `out_stb_b`.
- R6: A realignment holds both strobes for one word period. The word shown during the hold gets no rising edge, and no strobe level lasts less than one word period (two cycles).
- R7: Consecutive commas cause no realignment. Each one gets its own edge, and `comma_det` stays high across the whole run.
- R8: A code-group sampled at a tick edge appears on `out_cg` at the LAT_WORDS-th following tick edge. Between tick edges `out_cg` does not change.
- R9: While `rst` is high, `out_cg` becomes 0, `out_stb_b` 0, `out_stb_a` 1 and `comma_det` 0. The pipeline then delivers LAT_WORDS zero words before the first input word.
- R10: With `rate_half` low, no word is ever dropped, including the words before commas.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the word rate |
| rst | input | 1 | Synchronous active-high reset |
| rate_half | input | 1 | 1: complementary half-rate strobes; 0: single word-rate strobe |
| det_en | input | 1 | Enables the comma flag |
| in_tick | input | 1 | Marks the cycle carrying a new code-group (every other cycle) |
| rx_cg | input | 10 | Received code-group, bit 0 first on the line |
| out_cg | output | 10 | Delayed code-group |
| out_stb_a | output | 1 | Strobe A (complement of B in half-rate mode) |
| out_stb_b | output | 1 | Strobe B (the comma strobe) |
| comma_det | output | 1 | Comma flag for the word on `out_cg` |

## Verification
The scoreboard predicts which word each rising edge should capture and on which strobe, so a realignment that fires on the wrong word, fires on the wrong phase or fires inside a run of commas shows up as a shifted or duplicated word, or as a comma arriving on strobe A. Streams are built with an odd-length gap before a comma to force a hold, with runs of four commas, with both comma polarities, and with the enable low over commas. A design that shortens a strobe level during the hold is caught by the pulse-width check. A design with the wrong pipeline depth shows up as the wrong number of leading zero words. The word-rate mode is run over the same patterns to confirm that no word is ever dropped there.

// File: rtl/rxcg_pkg.sv
package rxcg_pkg;
   localparam int CG_W = 10;
   typedef logic [CG_W-1:0] cgroup_t;
   // low seven bits, bit 0 first on the line
   localparam logic [6:0] COMMA_POS = 7'b1111100;
   localparam logic [6:0] COMMA_NEG = 7'b0000011;
endpackage

// File: rtl/rxcg_comma_match.sv
module rxcg_comma_match #(
   parameter bit BOTH_SIGNS = 1'b1
) (
   input  rxcg_pkg::cgroup_t cg,
   output logic              hit
);
   generate
      if (BOTH_SIGNS) begin : g_both
         assign hit = (cg[6:0] == rxcg_pkg::COMMA_POS) ||
                      (cg[6:0] == rxcg_pkg::COMMA_NEG);
      end else begin : g_pos
         assign hit = (cg[6:0] == rxcg_pkg::COMMA_POS);
      end
   endgenerate
endmodule

// File: rtl/rxcg_delay.sv
module rxcg_delay #(
   parameter int DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adv,
   input  rxcg_pkg::cgroup_t din,
   output rxcg_pkg::cgroup_t head,
   output rxcg_pkg::cgroup_t ahead
);
   localparam int W = rxcg_pkg::CG_W;

   logic [DEPTH-1:0][W-1:0] stg;

   always_ff @(posedge clk) begin
      if (rst)      stg <= '0;
      else if (adv) stg <= {stg[DEPTH-2:0], din};
   end

   assign head  = stg[DEPTH-1];
   assign ahead = stg[DEPTH-2];
endmodule

// File: rtl/rxcg_strobe.sv
module rxcg_strobe (
   input  logic clk,
   input  logic rst,
   input  logic half,
   input  logic tick,
   input  logic hold,
   output logic stb_a,
   output logic stb_b
);
   logic mid;

   always_ff @(posedge clk) begin
      if (rst) mid <= 1'b0;
      else     mid <= tick;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         stb_b <= 1'b0;
         stb_a <= 1'b1;
      end else if (!half) begin
         stb_a <= 1'b1;
         if (tick)     stb_b <= 1'b0;
         else if (mid) stb_b <= 1'b1;
      end else if (mid && !hold) begin
         stb_b <= ~stb_b;
         stb_a <= stb_b;
      end else begin
         stb_a <= ~stb_b;
      end
   end
endmodule

// File: rtl/rxcg_aligner.sv
module rxcg_aligner #(
   parameter int LAT_WORDS  = 8,
   parameter bit BOTH_SIGNS = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       rate_half,
   input  logic       det_en,
   input  logic       in_tick,
   input  logic [9:0] rx_cg,
   output logic [9:0] out_cg,
   output logic       out_stb_a,
   output logic       out_stb_b,
   output logic       comma_det
);
   import rxcg_pkg::*;

   generate
      if (LAT_WORDS < 2) begin : g_bad_lat
         $error("rxcg_aligner: LAT_WORDS must be at least 2");
      end
   endgenerate

   cgroup_t head_w, ahead_w, out_q;
   logic    hit_head, hit_ahead;
   logic    comma_q, hold_q;

   rxcg_delay #(.DEPTH(LAT_WORDS)) u_dly (
      .clk(clk), .rst(rst), .adv(in_tick), .din(rx_cg),
      .head(head_w), .ahead(ahead_w)
   );

   rxcg_comma_match #(.BOTH_SIGNS(BOTH_SIGNS)) u_m_head (
      .cg(head_w), .hit(hit_head)
   );

   rxcg_comma_match #(.BOTH_SIGNS(BOTH_SIGNS)) u_m_ahead (
      .cg(ahead_w), .hit(hit_ahead)
   );

   // word boundary: load the bus and decide whether this word is held
   always_ff @(posedge clk) begin
      if (rst) begin
         out_q   <= '0;
         comma_q <= 1'b0;
         hold_q  <= 1'b0;
      end else if (in_tick) begin
         out_q   <= head_w;
         comma_q <= hit_head;
         hold_q  <= rate_half && hit_ahead && !hit_head && !out_stb_b;
      end
   end

   rxcg_strobe u_stb (
      .clk(clk), .rst(rst), .half(rate_half), .tick(in_tick), .hold(hold_q),
      .stb_a(out_stb_a), .stb_b(out_stb_b)
   );

   assign out_cg    = out_q;
   assign comma_det = comma_q & det_en;
endmodule

// File: rtl/rxcg_aligner_chk.sv
module rxcg_aligner_chk (
   input logic       clk,
   input logic       rst,
   input logic       rate_half,
   input logic       det_en,
   input logic       in_tick,
   input logic [9:0] out_cg,
   input logic       out_stb_a,
   input logic       out_stb_b,
   input logic       comma_det
);
   function automatic logic is_k(input logic [9:0] w);
      return (w[6:0] == 7'b1111100) || (w[6:0] == 7'b0000011);
   endfunction

   // R1, R2: flag tracks the bus word and the enable
   a_r2_flag_match: assert property (@(posedge clk) disable iff (rst)
      comma_det == (det_en && is_k(out_cg)));

   // R3: strobe A parked in word-rate mode
   a_r3_a_parked: assert property (@(posedge clk) disable iff (rst)
      (!rate_half && !$past(rate_half)) |-> out_stb_a);

   // R4: complementary pair in half-rate mode
   a_r4_complement: assert property (@(posedge clk) disable iff (rst)
      (rate_half && $past(rate_half)) |-> (out_stb_a != out_stb_b));

   // R6: no strobe level shorter than two cycles in half-rate mode
   a_r6_no_runt: assert property (@(posedge clk) disable iff (rst)
      (rate_half && $past(rate_half) && !$stable(out_stb_b)) |=> $stable(out_stb_b));

   // R5, R7: a comma reaches strobe A only when it follows another comma
   a_r5_comma_on_b: assert property (@(posedge clk) disable iff (rst)
      (rate_half && $past(rate_half) && $past(rate_half, 2) &&
       $rose(out_stb_a) && is_k(out_cg)) |-> is_k($past(out_cg, 2)));

   // R8: the bus moves only on a tick edge
   a_r8_bus_on_tick: assert property (@(posedge clk) disable iff (rst)
      !$stable(out_cg) |-> $past(in_tick));
endmodule

bind rxcg_aligner rxcg_aligner_chk u_chk (.*);

// File: tb/sim_rxcg_aligner.sv
`timescale 1ns/1ps
module sim_rxcg_aligner;
   localparam int LAT = 8;
   localparam logic [9:0] KP = 10'h17C;
   localparam logic [9:0] KN = 10'h283;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       rate_half = 1'b1;
   logic       det_en = 1'b1;
   logic       in_tick = 1'b0;
   logic [9:0] rx_cg = '0;
   logic [9:0] out_cg;
   logic       out_stb_a, out_stb_b, comma_det;

   always #4 clk = ~clk;

   rxcg_aligner #(.LAT_WORDS(LAT)) u0 (
      .clk(clk), .rst(rst), .rate_half(rate_half), .det_en(det_en),
      .in_tick(in_tick), .rx_cg(rx_cg), .out_cg(out_cg),
      .out_stb_a(out_stb_a), .out_stb_b(out_stb_b), .comma_det(comma_det)
   );

   typedef struct packed { logic [9:0] w; logic on_b; } exp_t;
   exp_t q[$];

   int   n_chk = 0, n_fail = 0;
   bit   done = 1'b0;
   logic [9:0] pend;
   bit   have_pend, nb, half_m;

   function automatic bit is_k(input logic [9:0] w);
      return (w[6:0] == 7'b1111100) || (w[6:0] == 7'b0000011);
   endfunction

   function automatic logic [9:0] dat(input int i);
      logic [9:0] v;
      v = 10'((i * 37 + 5) & 10'h3FF);
      if (is_k(v) || v == 10'h000) v = v ^ 10'h010;
      return v;
   endfunction

   // expected capture model: one word of lookahead
   task automatic model_feed(input logic [9:0] w);
      if (have_pend) begin
         if (half_m && nb && !is_k(pend) && is_k(w)) begin
            // held word: no edge, phase unchanged
         end else begin
            q.push_back('{w: pend, on_b: (half_m ? nb : 1'b1)});
            if (half_m) nb = !nb;
         end
      end
      pend = w;
      have_pend = 1'b1;
   endtask

   task automatic send(input logic [9:0] w, input logic en);
      @(negedge clk);
      rx_cg = w; det_en = en; in_tick = 1'b1;
      model_feed(w);
      @(negedge clk);
      in_tick = 1'b0;
   endtask

   task automatic do_reset(input logic half);
      @(negedge clk);
      rst = 1'b1; in_tick = 1'b0; rate_half = half; det_en = 1'b1;
      repeat (4) @(negedge clk);
      q.delete();
      have_pend = 1'b0; nb = 1'b1; half_m = half;
      for (int i = 0; i < LAT; i++) model_feed(10'h000);
      rst = 1'b0;
      @(negedge clk);
      #1;
      n_chk++;
      if (out_cg !== 10'h000 || out_stb_b !== 1'b0 || out_stb_a !== 1'b1 || comma_det !== 1'b0) begin
         n_fail++;
         $display("FAIL R9 reset state: cg=%h a=%b b=%b det=%b expected cg=000 a=1 b=0 det=0",
                  out_cg, out_stb_a, out_stb_b, comma_det);
      end
   endtask

   task automatic drain_and_check();
      for (int i = 0; i < LAT + 4; i++) send(10'h000, 1'b1);
      repeat (4) @(negedge clk);
      n_chk++;
      if (q.size() > LAT + 1) begin
         n_fail++;
         $display("FAIL R8 words left uncaptured: %0d expected at most %0d", q.size(), LAT + 1);
      end
   endtask

   // monitor: scoreboard on strobe edges plus per-cycle checks
   logic pa = 1'b1, pb = 1'b0;
   int   since_b = 100;
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst) begin
            pa = out_stb_a; pb = out_stb_b; since_b = 100;
         end else begin
            exp_t e;
            bit ra, rb;
            ra = out_stb_a && !pa;
            rb = out_stb_b && !pb;
            since_b++;
            // R1, R2, R7: flag
            n_chk++;
            if (comma_det !== (det_en && is_k(out_cg))) begin
               n_fail++;
               $display("FAIL R2 comma_det=%b expected %b (cg=%h en=%b)",
                        comma_det, det_en && is_k(out_cg), out_cg, det_en);
            end
            if (rate_half) begin
               n_chk++;
               if (out_stb_a === out_stb_b) begin
                  n_fail++;
                  $display("FAIL R4 strobes not complementary: a=%b b=%b expected a=%b",
                           out_stb_a, out_stb_b, !out_stb_b);
               end
               if (out_stb_b !== pb) begin
                  n_chk++;
                  if (since_b < 2) begin
                     n_fail++;
                     $display("FAIL R6 strobe level lasted %0d cycles expected >= 2", since_b);
                  end
                  since_b = 0;
               end
            end else if (ra) begin
               n_chk++; n_fail++;
               $display("FAIL R3 strobe A rose in word-rate mode: a=%b expected 1 held", out_stb_a);
            end
            if (ra || rb) begin
               n_chk++;
               if (q.size() == 0) begin
                  n_fail++;
                  $display("FAIL R4 unexpected edge: cg=%h expected no edge", out_cg);
               end else begin
                  e = q.pop_front();
                  if (out_cg !== e.w || rb !== e.on_b) begin
                     n_fail++;
                     $display("FAIL R5/R8/R10 captured cg=%h on_b=%b expected cg=%h on_b=%b",
                              out_cg, rb, e.w, e.on_b);
                  end
               end
            end
            pa = out_stb_a; pb = out_stb_b;
         end
      end
   end

   // watchdog
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 40000 && !done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog expired: cycles=%0d expected < 40000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // half-rate mode (R4, R5, R6, R7)
      do_reset(1'b1);
      for (int i = 0; i < 6; i++) begin send(KP, 1'b1); send(dat(i), 1'b1); end
      send(dat(50), 1'b1);                       // odd gap forces a hold (R6)
      for (int i = 0; i < 4; i++) begin send(KP, 1'b1); send(dat(60 + i), 1'b1); end
      for (int i = 0; i < 4; i++) send(KP, 1'b1); // run of commas (R7)
      send(dat(70), 1'b1); send(dat(71), 1'b1);
      send(KN, 1'b0); send(dat(72), 1'b0);       // enable low (R2)
      send(KN, 1'b1); send(dat(73), 1'b1); send(dat(74), 1'b1);
      send(KN, 1'b1); send(KP, 1'b1); send(KN, 1'b1); // mixed polarity run (R1)
      send(dat(75), 1'b1); send(dat(76), 1'b1); send(dat(77), 1'b1);
      send(KP, 1'b1); send(dat(78), 1'b1);
      drain_and_check();

      // word-rate mode (R3, R10)
      do_reset(1'b0);
      for (int i = 0; i < 5; i++) begin send(dat(100 + i), 1'b1); send(KP, 1'b1); end
      send(dat(110), 1'b1);
      for (int i = 0; i < 3; i++) send(KN, 1'b1);
      send(dat(111), 1'b0); send(KP, 1'b0); send(dat(112), 1'b1);
      for (int i = 0; i < 6; i++) send(dat(120 + i), 1'b1);
      drain_and_check();

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule